// File: doc/BRIEF.md
# Warp Load Pending Request Table

This block keeps track of warp-wide load instructions that are waiting on the lower memory level. It takes one instruction at a time. Each instruction carries a warp number, a mask of the active threads and one byte address per thread. On acceptance the instruction gets a table slot. The block then walks the active threads and emits one lower-level request for every distinct memory block they touch. Each request carries the block address, the slot number and the mask of the threads that the block serves.

Each slot holds the warp number, every thread's byte offset inside its block and a count of requests still outstanding. A returning response names the slot and a thread mask. The block forwards the response in the same cycle with the slot's warp number and the offsets of the threads it serves. On the last response of an instruction it flags the release, and the slot is free from the next cycle. The cache arrays, data storage and register writeback sit outside this block.

Top module: `warp_pend_table`

## Requirements
- R1: An instruction is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high exactly when at least one slot is free and no request generation is in progress.
- R2: A taken instruction with a non-empty mask occupies the lowest-numbered free slot, and every request it produces carries that slot number in `mreq_id_o`.
- R3: Requests start in the cycle after acceptance and come one per cycle, one for each distinct block. Each request is led by the lowest-numbered active thread that no earlier request has covered. The block address is thread address bits [ADDR_W-1:BLK_OFF_W].
- R4: Each request mask holds every not-yet-covered active thread whose block matches the leader's block. The masks of one instruction are non-empty and disjoint, and together they equal the active mask. Inactive threads never appear in a mask.
- R5: An instruction whose mask is all zero is accepted, produces no request and leaves every slot free.
- R6: While `rsp_valid_i` is high, `fwd_valid_o` is high in the same cycle. `fwd_warp_o` is the warp number stored for `rsp_id_i`. `fwd_mask_o` equals `rsp_mask_i` and `fwd_data_o` equals `rsp_data_i`.
- R7: Lane t of `fwd_off_o` (bits [t*BLK_OFF_W +: BLK_OFF_W]) holds the low BLK_OFF_W address bits of thread t when `fwd_mask_o[t]` is set. Otherwise the lane is zero.
- R8: `fwd_release_o` is high only on the response that brings a slot's outstanding count to zero after all of that slot's requests have been issued. The slot is free from the next cycle, and no earlier response frees it.
- R9: With every slot occupied, `req_ready_o` is low and an offered instruction produces no request.
- R10: `req_ready_o` is low in every cycle in which a request is being emitted.
- R11: After reset every slot is free, `req_ready_o` is high and `mreq_valid_o` is low.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Instruction offered |
| req_ready_o | output | 1 | Instruction can be taken |
| req_warp_i | input | WARP_ID_W | Warp number |
| req_mask_i | input | WARP_SIZE | Active thread mask |
| req_addr_i | input | WARP_SIZE*ADDR_W | Per-thread byte address, thread t at [t*ADDR_W +: ADDR_W] |
| mreq_valid_o | output | 1 | Lower-level request valid |
| mreq_blk_o | output | ADDR_W-BLK_OFF_W | Block address |
| mreq_id_o | output | ID_W | Slot number |
| mreq_mask_o | output | WARP_SIZE | Threads served by this block |
| rsp_valid_i | input | 1 | Response valid |
| rsp_id_i | input | ID_W | Slot number of the response |
| rsp_mask_i | input | WARP_SIZE | Threads served by the response |
| rsp_data_i | input | DATA_W | Response payload |
| fwd_valid_o | output | 1 | Forwarded response valid |
| fwd_warp_o | output | WARP_ID_W | Warp number of the slot |
| fwd_mask_o | output | WARP_SIZE | Threads to write |
| fwd_off_o | output | WARP_SIZE*BLK_OFF_W | Per-thread offsets inside the block |
| fwd_data_o | output | DATA_W | Forwarded payload |
| fwd_release_o | output | 1 | Last response of the slot; slot freed |

## Verification
The hardest state to reach from the ports is a full table that holds instructions with different numbers of outstanding requests. A partial response to one slot must leave the table full, and a completed slot must be reused ahead of higher-numbered ones. The bench first sweeps every active mask under four address patterns (unique, pairs, all-same and interleaved blocks). It then fills all slots without answering, with an empty-mask instruction in between. After that it answers one slot completely and another slot only in part. Finally it checks that the refilled slot number and the ready signal match the arithmetic model at each step.

// File: rtl/ptab_pkg.sv
package ptab_pkg;
  localparam int unsigned DEF_ENTRIES = 44;
  localparam int unsigned DEF_WARP    = 32;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_OFF_W   = 7;
  localparam int unsigned DEF_WID_W   = 6;
  localparam int unsigned DEF_DATA_W  = 32;
endpackage

// File: rtl/ptab_alloc.sv
module ptab_alloc #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  free_i,
  output logic          any_o,
  output logic [IW-1:0] id_o
);
  always_comb begin
    any_o = |free_i;
    id_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) id_o = IW'(i);
    end
  end
endmodule

// File: rtl/ptab_gather.sv
module ptab_gather #(
  parameter int unsigned WS = 4,
  parameter int unsigned BW = 8,
  parameter int unsigned IW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IW-1:0]    start_id_i,
  input  logic [WS-1:0]    mask_i,
  input  logic [WS*BW-1:0] blk_i,
  output logic             busy_o,
  output logic [WS-1:0]    mask_o,
  output logic [BW-1:0]    blk_o,
  output logic [IW-1:0]    id_o
);
  logic                   busy_q;
  logic [WS-1:0]          rem_q;
  logic [WS-1:0][BW-1:0]  blk_q;
  logic [IW-1:0]          id_q;
  logic [BW-1:0]          lead_blk;
  logic [WS-1:0]          match;
  logic                   found;

  // leader = lowest uncovered active thread
  always_comb begin
    found    = 1'b0;
    lead_blk = '0;
    for (int t = 0; t < WS; t++) begin
      if (!found && rem_q[t]) begin
        lead_blk = blk_q[t];
        found    = 1'b1;
      end
    end
    for (int t = 0; t < WS; t++) match[t] = rem_q[t] && (blk_q[t] == lead_blk);
  end

  assign busy_o = busy_q;
  assign mask_o = match;
  assign blk_o  = lead_blk;
  assign id_o   = id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      blk_q  <= '0;
      id_q   <= '0;
    end else if (start_i) begin
      busy_q <= |mask_i;
      rem_q  <= mask_i;
      blk_q  <= blk_i;
      id_q   <= start_id_i;
    end else if (busy_q) begin
      rem_q  <= rem_q & ~match;
      busy_q <= |(rem_q & ~match);
    end
  end
endmodule

// File: rtl/ptab_entries.sv
module ptab_entries #(
  parameter int unsigned N  = 4,
  parameter int unsigned WS = 4,
  parameter int unsigned OW = 4,
  parameter int unsigned WW = 3,
  parameter int unsigned CW = 3,
  parameter int unsigned IW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [IW-1:0]    alloc_id_i,
  input  logic [WW-1:0]    alloc_warp_i,
  input  logic [WS*OW-1:0] alloc_off_i,
  input  logic             gen_busy_i,
  input  logic [IW-1:0]    gen_id_i,
  input  logic             rsp_valid_i,
  input  logic [IW-1:0]    rsp_id_i,
  output logic [N-1:0]     free_o,
  output logic [WW-1:0]    rsp_warp_o,
  output logic [WS*OW-1:0] rsp_off_o,
  output logic             release_o
);
  logic [N-1:0]     vld_q;
  logic [CW-1:0]    cnt_q  [N];
  logic [WW-1:0]    warp_q [N];
  logic [WS*OW-1:0] off_q  [N];
  logic [CW-1:0]    cnt_nx [N];
  logic [N-1:0]     rel;
  logic             id_ok;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      logic hit_inc, hit_rsp, gen_here;
      gen_here  = gen_busy_i && (gen_id_i == IW'(e));
      hit_inc   = gen_here;
      hit_rsp   = rsp_valid_i && (rsp_id_i == IW'(e)) && vld_q[e];
      cnt_nx[e] = cnt_q[e] + CW'(hit_inc) - CW'(hit_rsp);
      // no release while the slot is still emitting requests
      rel[e]    = hit_rsp && (cnt_nx[e] == '0) && !gen_here;
    end
  end

  assign id_ok      = (32'(rsp_id_i) < N);
  assign free_o     = ~vld_q;
  assign release_o  = |rel;
  assign rsp_warp_o = id_ok ? warp_q[rsp_id_i] : '0;
  assign rsp_off_o  = id_ok ? off_q[rsp_id_i]  : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int e = 0; e < N; e++) begin
        cnt_q[e]  <= '0;
        warp_q[e] <= '0;
        off_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < N; e++) begin
        if (alloc_i && alloc_id_i == IW'(e)) begin
          vld_q[e]  <= 1'b1;
          cnt_q[e]  <= '0;
          warp_q[e] <= alloc_warp_i;
          off_q[e]  <= alloc_off_i;
        end else if (vld_q[e]) begin
          cnt_q[e] <= cnt_nx[e];
          if (rel[e]) vld_q[e] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/warp_pend_table.sv
module warp_pend_table #(
  parameter int unsigned NUM_ENTRIES = ptab_pkg::DEF_ENTRIES,
  parameter int unsigned WARP_SIZE   = ptab_pkg::DEF_WARP,
  parameter int unsigned ADDR_W      = ptab_pkg::DEF_ADDR_W,
  parameter int unsigned BLK_OFF_W   = ptab_pkg::DEF_OFF_W,
  parameter int unsigned WARP_ID_W   = ptab_pkg::DEF_WID_W,
  parameter int unsigned DATA_W      = ptab_pkg::DEF_DATA_W,
  localparam int unsigned ID_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int unsigned BLK_W = ADDR_W - BLK_OFF_W,
  localparam int unsigned CNT_W = $clog2(WARP_SIZE + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [WARP_ID_W-1:0]          req_warp_i,
  input  logic [WARP_SIZE-1:0]          req_mask_i,
  input  logic [WARP_SIZE*ADDR_W-1:0]   req_addr_i,
  output logic                          mreq_valid_o,
  output logic [BLK_W-1:0]              mreq_blk_o,
  output logic [ID_W-1:0]               mreq_id_o,
  output logic [WARP_SIZE-1:0]          mreq_mask_o,
  input  logic                          rsp_valid_i,
  input  logic [ID_W-1:0]               rsp_id_i,
  input  logic [WARP_SIZE-1:0]          rsp_mask_i,
  input  logic [DATA_W-1:0]             rsp_data_i,
  output logic                          fwd_valid_o,
  output logic [WARP_ID_W-1:0]          fwd_warp_o,
  output logic [WARP_SIZE-1:0]          fwd_mask_o,
  output logic [WARP_SIZE*BLK_OFF_W-1:0] fwd_off_o,
  output logic [DATA_W-1:0]             fwd_data_o,
  output logic                          fwd_release_o
);
  logic [NUM_ENTRIES-1:0]         free;
  logic                           any_free;
  logic [ID_W-1:0]                alloc_id;
  logic                           gen_busy;
  logic [ID_W-1:0]                gen_id;
  logic                           accept, alloc;
  logic [WARP_SIZE*BLK_OFF_W-1:0] off_in, ent_off;
  logic [WARP_SIZE*BLK_W-1:0]     blk_in;

  assign req_ready_o = any_free && !gen_busy;
  assign accept      = req_valid_i && req_ready_o;
  assign alloc       = accept && (|req_mask_i);

  for (genvar t = 0; t < WARP_SIZE; t++) begin : g_lane
    assign off_in[t*BLK_OFF_W +: BLK_OFF_W] =
      req_mask_i[t] ? req_addr_i[t*ADDR_W +: BLK_OFF_W] : '0;
    assign blk_in[t*BLK_W +: BLK_W] = req_addr_i[t*ADDR_W + BLK_OFF_W +: BLK_W];
    assign fwd_off_o[t*BLK_OFF_W +: BLK_OFF_W] =
      rsp_mask_i[t] ? ent_off[t*BLK_OFF_W +: BLK_OFF_W] : '0;
  end

  ptab_alloc #(.N(NUM_ENTRIES)) u_alloc (
    .free_i (free),
    .any_o  (any_free),
    .id_o   (alloc_id)
  );

  ptab_gather #(.WS(WARP_SIZE), .BW(BLK_W), .IW(ID_W)) u_gather (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (alloc),
    .start_id_i (alloc_id),
    .mask_i     (req_mask_i),
    .blk_i      (blk_in),
    .busy_o     (gen_busy),
    .mask_o     (mreq_mask_o),
    .blk_o      (mreq_blk_o),
    .id_o       (gen_id)
  );

  ptab_entries #(
    .N(NUM_ENTRIES), .WS(WARP_SIZE), .OW(BLK_OFF_W),
    .WW(WARP_ID_W), .CW(CNT_W), .IW(ID_W)
  ) u_entries (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (alloc),
    .alloc_id_i   (alloc_id),
    .alloc_warp_i (req_warp_i),
    .alloc_off_i  (off_in),
    .gen_busy_i   (gen_busy),
    .gen_id_i     (gen_id),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_id_i     (rsp_id_i),
    .free_o       (free),
    .rsp_warp_o   (fwd_warp_o),
    .rsp_off_o    (ent_off),
    .release_o    (fwd_release_o)
  );

  assign mreq_valid_o = gen_busy;
  assign mreq_id_o    = gen_id;
  assign fwd_valid_o  = rsp_valid_i;
  assign fwd_mask_o   = rsp_mask_i;
  assign fwd_data_o   = rsp_data_i;
endmodule

// File: rtl/ptab_chk.sv
module ptab_chk #(
  parameter int unsigned WARP_SIZE = 4,
  parameter int unsigned BLK_OFF_W = 4,
  parameter int unsigned ID_W      = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_valid_i,
  input logic                           req_ready_o,
  input logic [WARP_SIZE-1:0]           req_mask_i,
  input logic                           mreq_valid_o,
  input logic [ID_W-1:0]                mreq_id_o,
  input logic [WARP_SIZE-1:0]           mreq_mask_o,
  input logic                           fwd_valid_o,
  input logic [WARP_SIZE-1:0]           fwd_mask_o,
  input logic [WARP_SIZE*BLK_OFF_W-1:0] fwd_off_o,
  input logic                           fwd_release_o
);
  // R3
  first_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (|req_mask_i)) |=>
      (mreq_valid_o && ((mreq_mask_o & ~$past(req_mask_i)) == '0)));

  // R4
  disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_o && $past(mreq_valid_o)) |-> ((mreq_mask_o & $past(mreq_mask_o)) == '0));

  // R4
  nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_valid_o |-> (mreq_mask_o != '0));

  // R2
  burst_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_o && $past(mreq_valid_o)) |-> $stable(mreq_id_o));

  // R10
  busy_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_valid_o |-> !req_ready_o);

  // R8
  release_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_release_o |-> fwd_valid_o);

  // R8
  release_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_release_o |=> (req_ready_o || mreq_valid_o));

  for (genvar t = 0; t < WARP_SIZE; t++) begin : g_off
    // R7
    idle_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_valid_o && !fwd_mask_o[t]) |-> (fwd_off_o[t*BLK_OFF_W +: BLK_OFF_W] == '0));
  end
endmodule

bind warp_pend_table ptab_chk #(
  .WARP_SIZE(WARP_SIZE), .BLK_OFF_W(BLK_OFF_W), .ID_W(ID_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_mask_i    (req_mask_i),
  .mreq_valid_o  (mreq_valid_o),
  .mreq_id_o     (mreq_id_o),
  .mreq_mask_o   (mreq_mask_o),
  .fwd_valid_o   (fwd_valid_o),
  .fwd_mask_o    (fwd_mask_o),
  .fwd_off_o     (fwd_off_o),
  .fwd_release_o (fwd_release_o)
);

// File: tb/tb_warp_pend_table.sv
`timescale 1ns/1ps
module tb_warp_pend_table;
  localparam int N  = 4;
  localparam int WS = 4;
  localparam int AW = 12;
  localparam int OW = 4;
  localparam int WW = 3;
  localparam int DW = 8;
  localparam int IW = 2;
  localparam int BW = AW - OW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 0;
  logic              req_ready;
  logic [WW-1:0]     req_warp = '0;
  logic [WS-1:0]     req_mask = '0;
  logic [WS*AW-1:0]  req_addr = '0;
  logic              mreq_valid;
  logic [BW-1:0]     mreq_blk;
  logic [IW-1:0]     mreq_id;
  logic [WS-1:0]     mreq_mask;
  logic              rsp_valid = 0;
  logic [IW-1:0]     rsp_id = '0;
  logic [WS-1:0]     rsp_mask = '0;
  logic [DW-1:0]     rsp_data = '0;
  logic              fwd_valid;
  logic [WW-1:0]     fwd_warp;
  logic [WS-1:0]     fwd_mask;
  logic [WS*OW-1:0]  fwd_off;
  logic [DW-1:0]     fwd_data;
  logic              fwd_release;

  warp_pend_table #(
    .NUM_ENTRIES(N), .WARP_SIZE(WS), .ADDR_W(AW),
    .BLK_OFF_W(OW), .WARP_ID_W(WW), .DATA_W(DW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_warp_i(req_warp),
    .req_mask_i(req_mask), .req_addr_i(req_addr),
    .mreq_valid_o(mreq_valid), .mreq_blk_o(mreq_blk), .mreq_id_o(mreq_id),
    .mreq_mask_o(mreq_mask),
    .rsp_valid_i(rsp_valid), .rsp_id_i(rsp_id), .rsp_mask_i(rsp_mask),
    .rsp_data_i(rsp_data),
    .fwd_valid_o(fwd_valid), .fwd_warp_o(fwd_warp), .fwd_mask_o(fwd_mask),
    .fwd_off_o(fwd_off), .fwd_data_o(fwd_data), .fwd_release_o(fwd_release)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [AW-1:0] a [WS];
  int            ng;
  logic [WS-1:0] gm [WS];
  logic [BW-1:0] gb [WS];
  bit            bfree [N];
  logic [AW-1:0] ea [N][WS];
  logic [WS-1:0] egm [N][WS];
  int            eng [N];
  int            esent [N];
  logic [WW-1:0] ewarp [N];

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic int low_free();
    for (int i = 0; i < N; i++) if (bfree[i]) return i;
    return -1;
  endfunction

  // address pattern p: 0 unique, 1 pairs, 2 all same, 3 interleaved
  task automatic build(input int p, input int m);
    for (int t = 0; t < WS; t++) begin
      int grp;
      grp = (p == 0) ? t : (p == 1) ? t / 2 : (p == 2) ? 0 : t % 2;
      a[t] = {BW'(m * 4 + grp + p * 64), OW'((t * 5 + p * 3 + m) & 15)};
    end
  endtask

  task automatic calc_groups(input logic [WS-1:0] m);
    logic [WS-1:0] rem;
    rem = m;
    ng = 0;
    while (rem != '0) begin
      int l;
      logic [WS-1:0] mm;
      l = 0;
      for (int t = WS - 1; t >= 0; t--) if (rem[t]) l = t;
      mm = '0;
      for (int t = 0; t < WS; t++)
        if (rem[t] && a[t][AW-1:OW] == a[l][AW-1:OW]) mm[t] = 1'b1;
      gm[ng] = mm;
      gb[ng] = a[l][AW-1:OW];
      ng++;
      rem = rem & ~mm;
    end
  endtask

  task automatic issue(input logic [WW-1:0] w, input logic [WS-1:0] m, input bit exp_ready);
    int id;
    calc_groups(m);
    id = low_free();
    @(negedge clk);
    req_valid = 1'b1;
    req_warp = w;
    req_mask = m;
    for (int t = 0; t < WS; t++) req_addr[t*AW +: AW] = a[t];
    #1;
    chk(req_ready == exp_ready, "R1/R9 ready", req_ready, exp_ready);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (!exp_ready) begin
      chk(!mreq_valid, "R9 refused makes no request", mreq_valid, 0);
      return;
    end
    if (m == '0) begin
      chk(!mreq_valid, "R5 empty mask no request", mreq_valid, 0);
      chk(req_ready == (id >= 0), "R5 no slot taken", req_ready, 1);
      return;
    end
    for (int j = 0; j < ng; j++) begin
      chk(mreq_valid, "R3 request valid", mreq_valid, 1);
      chk(mreq_blk == gb[j], "R3 block address", mreq_blk, gb[j]);
      chk(mreq_mask == gm[j], "R4 request mask", mreq_mask, gm[j]);
      chk(mreq_id == IW'(id), "R2 slot id", mreq_id, id);
      if (j == 0) chk(!req_ready, "R10 ready low while emitting", req_ready, 0);
      @(negedge clk);
      #1;
    end
    chk(!mreq_valid, "R3 request count", mreq_valid, 0);
    bfree[id] = 0;
    eng[id] = ng;
    esent[id] = 0;
    ewarp[id] = w;
    for (int t = 0; t < WS; t++) begin
      ea[id][t] = a[t];
      egm[id][t] = gm[t];
    end
  endtask

  task automatic respond(input int id, input logic [DW-1:0] d);
    int j;
    bit last;
    logic [WS*OW-1:0] eo;
    j = eng[id] - 1 - esent[id];
    esent[id]++;
    last = (esent[id] == eng[id]);
    for (int t = 0; t < WS; t++)
      eo[t*OW +: OW] = egm[id][j][t] ? ea[id][t][OW-1:0] : '0;
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_id = IW'(id);
    rsp_mask = egm[id][j];
    rsp_data = d;
    #1;
    chk(fwd_valid, "R6 forward valid", fwd_valid, 1);
    chk(fwd_warp == ewarp[id], "R6 warp", fwd_warp, ewarp[id]);
    chk(fwd_mask == egm[id][j], "R6 mask", fwd_mask, egm[id][j]);
    chk(fwd_data == d, "R6 data", fwd_data, d);
    chk(fwd_off == eo, "R7 offsets", fwd_off, eo);
    chk(fwd_release == last, "R8 release", fwd_release, last);
    @(negedge clk);
    rsp_valid = 1'b0;
    if (last) bfree[id] = 1;
    #1;
  endtask

  task automatic drain(input int id);
    while (esent[id] < eng[id]) respond(id, DW'(id * 37 + esent[id]));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      bfree[i] = 1;
      eng[i] = 0;
      esent[i] = 0;
    end
    #12;
    chk(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
    chk(mreq_valid == 1'b0, "R11 reset no request", mreq_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);

    // sweep every mask under every pattern
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 16; m++) begin
        build(p, m);
        issue(WW'(m + p), WS'(m), 1'b1);
        if (m != 0) begin
          drain(0);
          chk(req_ready, "R8 slot freed after last response", req_ready, 1);
        end
      end
    end

    // fill the table; empty mask in between takes no slot (R5)
    build(0, 15); issue(3'd1, 4'hF, 1'b1);
    build(1, 15); issue(3'd2, 4'hF, 1'b1);
    build(3, 11); issue(3'd3, 4'hB, 1'b1);
    build(2, 0);  issue(3'd4, 4'h0, 1'b1);
    build(3, 14); issue(3'd5, 4'hE, 1'b1);
    chk(!req_ready, "R9 full table refuses", req_ready, 0);
    build(1, 6);  issue(3'd6, 4'h6, 1'b0);

    // free slot 2, reuse goes to slot 2 (R2)
    drain(2);
    chk(req_ready, "R8 freed slot readies", req_ready, 1);
    build(0, 9); issue(3'd7, 4'h9, 1'b1);
    chk(!req_ready, "R9 full again", req_ready, 0);

    // partial answer keeps slot (R8)
    respond(1, 8'hA5);
    chk(!req_ready, "R8 partial response keeps slot", req_ready, 0);

    for (int i = 0; i < N; i++) drain(i);
    chk(req_ready, "R1 all free ready", req_ready, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule